// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer that sits beside each processor's local interrupt controller. A free-running system clock is divided by a power-of-two prescaler to give timer ticks. Software sets three things through a small register write port: a timer vector entry, a divide setting and an initial count. The vector entry holds an 8-bit vector, a mask bit and a periodic/one-shot select. Writing the initial count starts a countdown from the moment of that write.

One timer period lasts the initial count plus one prescaled ticks. When a period ends, the block sends a one-cycle interrupt request that carries the vector from the entry. The request is sent only if the entry is unmasked and the global enable input is high. In periodic mode the countdown starts again on its own. In one-shot mode it stops at zero. An initial count of zero leaves the timer idle in either mode.

Two values can be read at any time. The current count gives the ticks left in the present period. The pending-expiry output gives the number of ticks until the next interrupt that will actually be sent, and reads all ones when none is scheduled.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, irq_pulse is 0, cur_count is 0 and pend_ticks is all ones. The vector entry comes up masked in one-shot mode with vector 0. The divide setting and the initial count come up as 0.
- R2: The tick period is 2^S system clocks, where S is the low three bits of the 4-bit divide register (wr_sel=2). Bit 3 of that register is ignored.
- R3: In one-shot mode (entry bit 17 = 0), a write of initial count N > 0 (wr_sel=1) gives exactly one pulse. The pulse comes (N+1)*2^S clocks after the write edge. After it, cur_count stays 0.
- R4: In periodic mode (entry bit 17 = 1), a pulse comes every (N+1)*2^S clocks, counted from the write edge.
- R5: An initial count of 0 gives no pulse in either mode, and pend_ticks reads all ones.
- R6: While the entry mask bit (bit 16) is 1, no pulse is sent and pend_ticks is all ones. The countdown keeps running.
- R7: While glb_en is 0, no pulse is sent. The countdown keeps running.
- R8: Writing the initial count during a countdown restarts both the countdown and the prescaler from that write edge.
- R9: A pulse lasts exactly one cycle. While it is high, irq_vector shows the entry vector (bits 7:0).
- R10: cur_count starts at N after the load. It drops by one on each tick and holds 0 after a one-shot has finished. In periodic mode it goes back to N on the tick that sends the pulse.
- R11: When the timer is armed and unmasked, pend_ticks equals cur_count+1.
- R12: A new divide setting takes effect at the next tick boundary, or at the next initial-count write. It never takes effect partway through a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| glb_en | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 vector entry, 1 initial count, 2 divide, 3 unused |
| wr_data | input | 32 | Write data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with irq_pulse |
| cur_count | output | 32 | Ticks left in the present period |
| pend_ticks | output | 33 | Ticks until the next interrupt that will be sent, all ones if none is scheduled |

## Verification
Each write is taken on one rising edge. A pulse caused by that write is registered and appears after edge (N+1)*2^S. The bench therefore counts falling edges from the write edge and checks irq_pulse once per cycle across a window. Within that window it expects a 1 only at the computed cycle(s) and a 0 everywhere else. cur_count and pend_ticks come straight from state, so they can be checked one cycle after the edge that changed them. For the divide-change case the bench works out by hand how long the current tick lasts before the new shift takes effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

  localparam int ENT_VEC_LSB  = 0;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;
  localparam int VEC_W        = 8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift_req,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [PRE_W:0]     lim_full;

  assign lim_full = ((PRE_W+1)'(1) << shift_q) - (PRE_W+1)'(1);
  assign tick     = (pre_q == lim_full[PRE_W-1:0]);

  always_comb begin
    pre_d   = pre_q + PRE_W'(1);
    shift_d = shift_q;
    if (restart || tick) begin
      pre_d   = '0;
      shift_d = shift_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      shift_q <= '0;
    end else begin
      pre_q   <= pre_d;
      shift_q <= shift_d;
    end
  end

  // R8
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
  // R12
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(shift_q));
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             armed,
  output logic             expire
);
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             armed_q, armed_d;

  assign expire = tick && armed_q && (cur_q == '0) && !load;
  assign cur    = cur_q;
  assign armed  = armed_q;

  always_comb begin
    cur_d   = cur_q;
    armed_d = armed_q;
    if (load) begin
      cur_d   = load_val;
      armed_d = (load_val != '0);
    end else if (expire) begin
      if (periodic) cur_d = reload_val;
      else          armed_d = 1'b0;
    end else if (tick && armed_q) begin
      cur_d = cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      armed_q <= armed_d;
    end
  end

  // R10
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && armed_q && cur_q != '0) |=> (cur_q == $past(cur_q) - CNT_W'(1)));
  // R3
  oneshot_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !load) |=> (!armed_q && cur_q == '0));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      glb_en,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  output logic                      irq_pulse,
  output logic [tmr_pkg::VEC_W-1:0] irq_vector,
  output logic [CNT_W-1:0]          cur_count,
  output logic [CNT_W:0]            pend_ticks
);
  import tmr_pkg::*;
  localparam int DIV_W = SHIFT_W + 1;

  logic             rst_s1, rst_sn;
  logic [VEC_W-1:0] vec_q, vec_d, out_vec_q, out_vec_d;
  logic             mask_q, mask_d, per_q, per_d, irq_q, irq_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] init_q, init_d, cur_w;
  logic             load, tick, armed_w, expire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  assign load = wr_en && (wr_sel_e'(wr_sel) == SEL_INIT);

  always_comb begin
    vec_d  = vec_q;
    mask_d = mask_q;
    per_d  = per_q;
    div_d  = div_q;
    init_d = init_q;
    if (wr_en) begin
      case (wr_sel_e'(wr_sel))
        SEL_ENTRY: begin
          vec_d  = wr_data[ENT_VEC_LSB +: VEC_W];
          mask_d = wr_data[ENT_MASK_BIT];
          per_d  = wr_data[ENT_PER_BIT];
        end
        SEL_INIT: init_d = wr_data[CNT_W-1:0];
        SEL_DIV:  div_d  = wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
    irq_d     = expire_w && !mask_q && glb_en;
    out_vec_d = expire_w ? vec_q : out_vec_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vec_q     <= '0;
      mask_q    <= 1'b1;
      per_q     <= 1'b0;
      div_q     <= '0;
      init_q    <= '0;
      irq_q     <= 1'b0;
      out_vec_q <= '0;
    end else begin
      vec_q     <= vec_d;
      mask_q    <= mask_d;
      per_q     <= per_d;
      div_q     <= div_d;
      init_q    <= init_d;
      irq_q     <= irq_d;
      out_vec_q <= out_vec_d;
    end
  end

  tmr_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_sn),
    .restart   (load),
    .shift_req (div_q[SHIFT_W-1:0]),
    .tick      (tick)
  );

  tmr_down_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sn),
    .tick       (tick),
    .load       (load),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_q),
    .periodic   (per_q),
    .cur        (cur_w),
    .armed      (armed_w),
    .expire     (expire_w)
  );

  assign irq_pulse  = irq_q;
  assign irq_vector = out_vec_q;
  assign cur_count  = cur_w;
  assign pend_ticks = (armed_w && !mask_q) ? ({1'b0, cur_w} + (CNT_W+1)'(1)) : '1;

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_q |=> !irq_q);
  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_q |-> $past(!mask_q && glb_en));
  // R5
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (load && wr_data[CNT_W-1:0] == '0) |=> !armed_w);
endmodule

// File: tb/irq_countdown_timer_tb_top.sv
module irq_countdown_timer_tb_top;
  logic        clk, rst_n, glb_en, wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;
  logic [31:0] cur_count;
  logic [32:0] pend_ticks;
  int n_chk = 0;
  int n_fail = 0;
  localparam logic [32:0] NONE = '1;

  irq_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
    .cur_count(cur_count), .pend_ticks(pend_ticks)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(logic [1:0] sel, logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] ent(logic [7:0] v, logic m, logic p);
    return {14'd0, p, m, 8'd0, v};
  endfunction

  // watch n cycles; pulse expected at cycle first, then every period (0 = once)
  task automatic watch(int n, int first, int period, logic [7:0] vec, string tag);
    for (int i = 1; i <= n; i++) begin
      logic e;
      @(negedge clk);
      e = (first > 0) && ((i == first) ||
          (period > 0 && i > first && ((i - first) % period) == 0));
      chk(tag, 64'(irq_pulse), 64'(e));
      if (e) chk({tag, " vector (R9)"}, 64'(irq_vector), 64'(vec));
    end
  endtask

  task automatic t_reset;
    chk("R1 irq", 64'(irq_pulse), 64'd0);
    chk("R1 cur", 64'(cur_count), 64'd0);
    chk("R1 pend", 64'(pend_ticks), 64'(NONE));
    wr(2'd1, 32'd1);               // entry still masked, one-shot by default
    chk("R1 masked entry pend", 64'(pend_ticks), 64'(NONE));
    watch(6, 0, 0, 8'h0, "R1 masked entry no pulse");
    wr(2'd1, 32'd0);
  endtask

  task automatic t_oneshot;
    wr(2'd2, 32'h9);               // bit3 ignored -> shift 1 (R2)
    wr(2'd0, ent(8'h41, 1'b0, 1'b0));
    wr(2'd1, 32'd4);
    chk("R10 cur after load", 64'(cur_count), 64'd4);
    chk("R11 pend after load", 64'(pend_ticks), 64'd5);
    watch(40, 10, 0, 8'h41, "R3 R2 oneshot timing");
    chk("R3 cur after done", 64'(cur_count), 64'd0);
    chk("R11 pend after done", 64'(pend_ticks), 64'(NONE));
  endtask

  task automatic t_periodic;
    wr(2'd2, 32'h0);
    wr(2'd0, ent(8'h5a, 1'b0, 1'b1));
    wr(2'd1, 32'd2);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      chk("R4 periodic pulse", 64'(irq_pulse), 64'((i % 3) == 0));
      chk("R10 periodic cur", 64'(cur_count), 64'(2 - (i % 3)));
      chk("R11 periodic pend", 64'(pend_ticks), 64'(3 - (i % 3)));
    end
    wr(2'd1, 32'd0);
  endtask

  task automatic t_zero;
    wr(2'd0, ent(8'h11, 1'b0, 1'b1));
    wr(2'd1, 32'd0);
    chk("R5 periodic zero pend", 64'(pend_ticks), 64'(NONE));
    watch(20, 0, 0, 8'h0, "R5 periodic zero");
    wr(2'd0, ent(8'h11, 1'b0, 1'b0));
    wr(2'd1, 32'd0);
    watch(20, 0, 0, 8'h0, "R5 oneshot zero");
  endtask

  task automatic t_mask;
    wr(2'd0, ent(8'h22, 1'b1, 1'b1));
    wr(2'd1, 32'd1);
    chk("R6 pend masked", 64'(pend_ticks), 64'(NONE));
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R6 masked no pulse", 64'(irq_pulse), 64'd0);
      chk("R6 masked still counts", 64'(cur_count), 64'((i % 2) == 0 ? 1 : 0));
    end
    wr(2'd1, 32'd0);
  endtask

  task automatic t_glb;
    glb_en = 1'b0;
    wr(2'd0, ent(8'h33, 1'b0, 1'b1));
    wr(2'd1, 32'd1);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R7 disabled no pulse", 64'(irq_pulse), 64'd0);
      chk("R7 disabled still counts", 64'(cur_count), 64'((i % 2) == 0 ? 1 : 0));
    end
    wr(2'd1, 32'd0);
    glb_en = 1'b1;
  endtask

  task automatic t_reload;
    wr(2'd0, ent(8'h44, 1'b0, 1'b0));
    wr(2'd1, 32'd5);
    watch(3, 0, 0, 8'h0, "R8 before reload");
    wr(2'd1, 32'd5);
    chk("R8 cur restarted", 64'(cur_count), 64'd5);
    watch(12, 6, 0, 8'h44, "R8 reload timing");
  endtask

  task automatic t_divchange;
    wr(2'd2, 32'h0);
    wr(2'd0, ent(8'h66, 1'b0, 1'b0));
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h1);               // takes effect from the second tick edge on
    watch(12, 5, 0, 8'h66, "R12 divide at tick boundary");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_oneshot();
    t_periodic();
    t_zero();
    t_mask();
    t_glb();
    t_reload();
    t_divchange();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule